// File: doc/BRIEF.md
# Fetch Address Region Remapper

This block sits on an instruction fetch address path in front of the memory ports. It holds a small set of region descriptors. Each descriptor names a naturally aligned window of the 512 MB code space, sized from 2 MB to 128 MB, and a target window that the fetch is moved to. Every fetch address is compared against all enabled descriptors at once. The lowest-numbered descriptor that matches rewrites the upper address bits and picks the master port and the burst style for that fetch. A fetch that matches nothing leaves the block unchanged, on the default port with an incrementing burst.

Descriptors are loaded one whole word at a time. A load is refused while the cache in front of the block is switched on. A load that would enable a descriptor that is already enabled is also refused, so a live descriptor has to be switched off before it is given new contents. The translated result is registered and appears one clock after the fetch is presented.

Top module: `addr_remap_unit`

## Requirements
- R1: While reset is asserted and after it is released, every descriptor is disabled and all result outputs are zero.
- R2: The result outputs for a fetch appear on the clock edge after the fetch is presented, and `out_valid_o` copies `fetch_valid_i` delayed by one clock.
- R3: A fetch that hits no descriptor comes out with its address unchanged, `out_hit_o` = 0, `out_port_o` = 0 (master port 1), `out_wrap_o` = 0 (incrementing) and `out_region_o` = 0.
- R4: A descriptor with size code k (1..7, region size 2^k MB) matches when fetch address bits [28:21] equal its base field with the lowest k-1 bits of both left out of the comparison. Address bits [31:29] never take part.
- R5: On a hit, output bits [31:21+k-1] come from remap field bits [10:k-1], and output bits below bit 21+k-1 are the fetch address bits unchanged.
- R6: On a hit, `out_port_o` is the descriptor's port select (0 = master port 1, 1 = master port 2), `out_wrap_o` is its burst select (1 = wrapping, 0 = incrementing), and `out_region_o` is its number.
- R7: When several enabled descriptors match, the one with the lowest number supplies the result.
- R8: A descriptor load presented while `cache_en_i` = 1 leaves every descriptor unchanged.
- R9: A load with the enable bit set to a descriptor that is already enabled is refused. A load with the enable bit clear is accepted and disables the descriptor.
- R10: A descriptor whose size code is 0 never matches, even when enabled.
- R11: A disabled descriptor never matches, whatever its other fields hold.
- R12: A descriptor word places the enable at bit 0, the size code at bits [3:1], the base field at [11:4], the remap field at [22:12], the port select at bit 23 and the burst select at bit 24. An accepted load takes effect for fetches presented on the next clock and later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cache_en_i | input | 1 | Cache switched on; blocks all descriptor loads |
| cfg_we_i | input | 1 | Descriptor load strobe |
| cfg_idx_i | input | 2 | Number of the descriptor being loaded |
| cfg_data_i | input | 25 | Descriptor word, layout as in R12 |
| fetch_valid_i | input | 1 | A fetch address is presented |
| fetch_addr_i | input | 32 | Fetch address |
| out_valid_o | output | 1 | Registered result is valid |
| out_addr_o | output | 32 | Translated (or passed-through) address |
| out_hit_o | output | 1 | Some descriptor matched |
| out_region_o | output | 2 | Number of the matching descriptor, 0 on a miss |
| out_port_o | output | 1 | Master port select, 0 = port 1, 1 = port 2 |
| out_wrap_o | output | 1 | Burst select, 1 = wrapping, 0 = incrementing |

## Verification
Every translation result is due exactly one clock after its fetch is presented. A descriptor load changes translations only for fetches presented on the clock after the load edge. A fetch presented in the same cycle as a load still sees the old descriptors. The bench drives each stimulus on the falling edge, updates its behavioural model at the rising edge in the order fetch-then-load, and compares all result outputs at the next falling edge. Each result is thus checked in the single cycle it is due, and the same-cycle load and fetch ordering is covered by the random phase.

// File: rtl/remap_pkg.sv
`timescale 1ns/1ps
package remap_pkg;

    // Architectural geometry of the code space.
    localparam int ADDR_W     = 32;
    localparam int REGION_LSB = 21;               // 2 MB granule
    localparam int BASE_W     = 8;                // compares addr[28:21]
    localparam int REMAP_W    = ADDR_W - REGION_LSB;
    localparam int SIZE_W     = 3;
    localparam int BASE_HI    = REGION_LSB + BASE_W - 1;

    // Descriptor word, bit 0 is the enable.
    typedef struct packed {
        logic               wrap;    // 1 = wrapping burst
        logic               port;    // 0 = master port 1, 1 = master port 2
        logic [REMAP_W-1:0] remap;   // target address bits [31:21]
        logic [BASE_W-1:0]  base;    // source address bits [28:21]
        logic [SIZE_W-1:0]  size;    // 1..7 = 2 MB..128 MB, 0 = inert
        logic               en;
    } region_cfg_t;

    localparam int CFG_W = $bits(region_cfg_t);

endpackage

// File: rtl/remap_region.sv
`timescale 1ns/1ps
module remap_region
    import remap_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_sel_i,
    input  logic              lock_i,
    input  region_cfg_t       wdata_i,
    input  logic [ADDR_W-1:0] addr_i,
    output region_cfg_t       cfg_o,
    output logic              hit_o,
    output logic [ADDR_W-1:0] xaddr_o
);

    region_cfg_t cfg_d, cfg_q;
    logic        accept;

    // Load guard: no loads while locked, and no enabling over a live entry.
    always_comb begin
        accept = wr_sel_i & ~lock_i & ~(cfg_q.en & wdata_i.en);
        cfg_d  = accept ? wdata_i : cfg_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    // Match and translation against the stored descriptor.
    logic [SIZE_W-1:0] drop;
    logic [BASE_W-1:0] base_mask;
    logic [ADDR_W-1:0] hi_mask;
    logic              size_ok;

    always_comb begin
        size_ok   = (cfg_q.size != '0);
        drop      = cfg_q.size - SIZE_W'(1);
        base_mask = {BASE_W{1'b1}} << drop;
        hi_mask   = {ADDR_W{1'b1}} << (REGION_LSB + int'(drop));
        hit_o     = cfg_q.en & size_ok &
                    (((addr_i[BASE_HI:REGION_LSB] ^ cfg_q.base) & base_mask) == '0);
        xaddr_o   = ({cfg_q.remap, {REGION_LSB{1'b0}}} & hi_mask) | (addr_i & ~hi_mask);
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/remap_select.sv
`timescale 1ns/1ps
module remap_select
    import remap_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]      hit_i,
    input  logic [ADDR_W-1:0] xaddr_i [N],
    input  region_cfg_t       cfg_i   [N],
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              port_o,
    output logic              wrap_o
);

    // Scan from the top so the lowest matching number is written last.
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        addr_o = addr_i;
        port_o = 1'b0;
        wrap_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                hit_o  = 1'b1;
                idx_o  = IDX_W'(i);
                addr_o = xaddr_i[i];
                port_o = cfg_i[i].port;
                wrap_o = cfg_i[i].wrap;
            end
        end
    end

endmodule

// File: rtl/addr_remap_unit.sv
`timescale 1ns/1ps
module addr_remap_unit
    import remap_pkg::*;
#(
    parameter  int NUM_REGIONS = 4,
    localparam int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cache_en_i,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic [CFG_W-1:0]  cfg_data_i,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              out_valid_o,
    output logic [ADDR_W-1:0] out_addr_o,
    output logic              out_hit_o,
    output logic [IDX_W-1:0]  out_region_o,
    output logic              out_port_o,
    output logic              out_wrap_o
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  region;
        logic              port;
        logic              wrap;
        logic [ADDR_W-1:0] addr;
    } result_t;

    region_cfg_t                  wdata;
    region_cfg_t                  cfg_arr  [NUM_REGIONS];
    logic [ADDR_W-1:0]            xaddr_arr[NUM_REGIONS];
    logic [NUM_REGIONS-1:0]       hit_vec;
    logic [NUM_REGIONS*CFG_W-1:0] cfg_flat;

    assign wdata = region_cfg_t'(cfg_data_i);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        logic sel;
        assign sel = cfg_we_i & (cfg_idx_i == IDX_W'(r));
        remap_region u_region (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_sel_i(sel),
            .lock_i  (cache_en_i),
            .wdata_i (wdata),
            .addr_i  (fetch_addr_i),
            .cfg_o   (cfg_arr[r]),
            .hit_o   (hit_vec[r]),
            .xaddr_o (xaddr_arr[r])
        );
        assign cfg_flat[r*CFG_W +: CFG_W] = cfg_arr[r];
    end

    logic              sel_hit;
    logic [IDX_W-1:0]  sel_idx;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_port;
    logic              sel_wrap;

    remap_select #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_select (
        .hit_i  (hit_vec),
        .xaddr_i(xaddr_arr),
        .cfg_i  (cfg_arr),
        .addr_i (fetch_addr_i),
        .hit_o  (sel_hit),
        .idx_o  (sel_idx),
        .addr_o (sel_addr),
        .port_o (sel_port),
        .wrap_o (sel_wrap)
    );

    result_t res_d, res_q;

    always_comb begin
        res_d.valid  = fetch_valid_i;
        res_d.hit    = sel_hit;
        res_d.region = sel_idx;
        res_d.port   = sel_port;
        res_d.wrap   = sel_wrap;
        res_d.addr   = sel_addr;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign out_valid_o  = res_q.valid;
    assign out_addr_o   = res_q.addr;
    assign out_hit_o    = res_q.hit;
    assign out_region_o = res_q.region;
    assign out_port_o   = res_q.port;
    assign out_wrap_o   = res_q.wrap;

endmodule

// File: rtl/addr_remap_checks.sv
`timescale 1ns/1ps
module addr_remap_checks
    import remap_pkg::*;
#(
    parameter  int NUM_REGIONS = 4,
    localparam int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         cache_en_i,
    input logic                         cfg_we_i,
    input logic [IDX_W-1:0]             cfg_idx_i,
    input logic [CFG_W-1:0]             cfg_data_i,
    input logic                         fetch_valid_i,
    input logic [ADDR_W-1:0]            fetch_addr_i,
    input logic                         out_valid_o,
    input logic [ADDR_W-1:0]            out_addr_o,
    input logic                         out_hit_o,
    input logic [IDX_W-1:0]             out_region_o,
    input logic                         out_port_o,
    input logic                         out_wrap_o,
    input logic [NUM_REGIONS*CFG_W-1:0] cfg_flat
);

    logic tgt_live;
    always_comb tgt_live = cfg_flat[int'(cfg_idx_i) * CFG_W];

    a_r2_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> out_valid_o == $past(fetch_valid_i));

    a_r3_miss_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_hit_o |-> (!out_port_o && !out_wrap_o && out_region_o == '0));

    a_r3_miss_address: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_valid_i |=> (out_hit_o || out_addr_o == $past(fetch_addr_i)));

    a_r5_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_valid_i |=> out_addr_o[REGION_LSB-1:0] == $past(fetch_addr_i[REGION_LSB-1:0]));

    a_r8_locked_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cache_en_i |=> $stable(cfg_flat));

    a_r9_no_reenable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && tgt_live && cfg_data_i[0]) |=> $stable(cfg_flat));

endmodule

bind addr_remap_unit addr_remap_checks #(.NUM_REGIONS(NUM_REGIONS)) u_checks (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cache_en_i   (cache_en_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_idx_i    (cfg_idx_i),
    .cfg_data_i   (cfg_data_i),
    .fetch_valid_i(fetch_valid_i),
    .fetch_addr_i (fetch_addr_i),
    .out_valid_o  (out_valid_o),
    .out_addr_o   (out_addr_o),
    .out_hit_o    (out_hit_o),
    .out_region_o (out_region_o),
    .out_port_o   (out_port_o),
    .out_wrap_o   (out_wrap_o),
    .cfg_flat     (cfg_flat)
);

// File: tb/addr_remap_unit_tb_top.sv
`timescale 1ns/1ps
module addr_remap_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [24:0] cfg_data = '0;
    logic        fv = 1'b0;
    logic [31:0] fa = '0;
    logic        o_valid, o_hit, o_port, o_wrap;
    logic [31:0] o_addr;
    logic [1:0]  o_region;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    addr_remap_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cache_en_i(cache_en),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
        .fetch_valid_i(fv), .fetch_addr_i(fa),
        .out_valid_o(o_valid), .out_addr_o(o_addr), .out_hit_o(o_hit),
        .out_region_o(o_region), .out_port_o(o_port), .out_wrap_o(o_wrap)
    );

    // Behavioural reference state.
    bit m_en[4];
    int m_size[4], m_base[4], m_remap[4], m_port[4], m_wrap[4];
    bit e_valid, e_hit, e_port, e_wrap;
    int e_region;
    logic [31:0] e_addr;

    function automatic logic [24:0] mk(int en, int size, int base, int remap, int port, int wrap);
        int v = en + size * 2 + base * 16 + remap * 4096 + port * (1 << 23) + wrap * (1 << 24);
        return v[24:0];
    endfunction

    task automatic model_fetch(bit valid, logic [31:0] addr);
        e_valid = valid; e_hit = 0; e_port = 0; e_wrap = 0; e_region = 0; e_addr = addr;
        for (int r = 0; r < 4; r++) begin
            int n, sh;
            longint hi, lo;
            if (e_hit || !m_en[r] || m_size[r] == 0) continue;
            n = m_size[r] - 1;
            if (((int'(addr[28:21])) >> n) != (m_base[r] >> n)) continue;
            sh = 21 + n;
            hi = ((longint'(m_remap[r]) << 21) >> sh) << sh;
            lo = longint'(addr) % (longint'(1) << sh);
            e_hit = 1; e_region = r; e_port = m_port[r][0]; e_wrap = m_wrap[r][0];
            e_addr = 32'(hi + lo);
        end
    endtask

    task automatic model_load(bit we, int idx, logic [24:0] d, bit cen);
        if (!we || cen) return;
        if (m_en[idx] && d[0]) return;
        m_en[idx] = d[0];
        m_size[idx] = int'(d[3:1]);
        m_base[idx] = int'(d[11:4]);
        m_remap[idx] = int'(d[22:12]);
        m_port[idx] = int'(d[23]);
        m_wrap[idx] = int'(d[24]);
    endtask

    task automatic compare(string tag);
        bit bad;
        vectors++;
        bad = (o_valid !== e_valid);
        if (e_valid)
            bad = bad || (o_hit !== e_hit) || (o_addr !== e_addr) || (o_port !== e_port) ||
                  (o_wrap !== e_wrap) || (int'(o_region) != e_region);
        if (bad) begin
            fails++;
            $display("FAIL %s: got v=%0b h=%0b r=%0d a=%08h p=%0b w=%0b, expected v=%0b h=%0b r=%0d a=%08h p=%0b w=%0b",
                     tag, o_valid, o_hit, o_region, o_addr, o_port, o_wrap,
                     e_valid, e_hit, e_region, e_addr, e_port, e_wrap);
        end
    endtask

    // One clock: drive on the falling edge, model at the rising edge, compare at the next falling edge.
    task automatic step(bit we, int idx, logic [24:0] d, bit cen, bit valid, logic [31:0] addr, string tag);
        cfg_we = we; cfg_idx = 2'(idx); cfg_data = d; cache_en = cen; fv = valid; fa = addr;
        @(posedge clk);
        model_fetch(valid, addr);
        model_load(we, idx, d, cen);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic load(int idx, logic [24:0] d, bit cen, string tag);
        step(1, idx, d, cen, 0, 32'h0, tag);
    endtask

    task automatic fetch(logic [31:0] addr, string tag);
        step(0, 0, '0, 0, 1, addr, tag);
    endtask

    function automatic logic [31:0] at(int blk, int off);
        return (32'(blk) << 21) | 32'(off);
    endfunction

    initial begin
        repeat (2000 * 100) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2: got no completion, expected the run to finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 4; r++) begin
            m_en[r] = 0; m_size[r] = 0; m_base[r] = 0; m_remap[r] = 0; m_port[r] = 0; m_wrap[r] = 0;
        end
        e_valid = 0; e_hit = 0; e_port = 0; e_wrap = 0; e_region = 0; e_addr = '0;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R3 / R11: nothing enabled.
        fetch(32'h1234_5678, "R3 miss empty");
        load(2, mk(0, 1, 8'h91, 11'h155, 1, 1), 0, "R11 load disabled");
        fetch(at(8'h91, 21'h00_0ABC), "R11 disabled entry");
        step(0, 0, '0, 0, 0, 32'hFFFF_FFFF, "R2 idle valid low");

        // R4 / R5 / R6 / R12: 2 MB entry.
        load(0, mk(1, 1, 8'h12, 11'h400, 1, 1), 0, "R12 load region0");
        fetch(at(8'h12, 21'h0A_BCDE), "R5 2MB hit");
        fetch(32'hA000_0000 | at(8'h12, 21'h1F_FFFF), "R4 upper bits ignored");
        fetch(at(8'h13, 21'h00_0010), "R4 neighbour misses");

        // R8: cache on blocks loads.
        load(1, mk(1, 2, 8'h40, 11'h7F0, 0, 1), 1, "R8 locked load");
        fetch(at(8'h40, 21'h00_1234), "R8 locked entry absent");
        load(0, mk(0, 1, 8'h12, 11'h400, 1, 1), 1, "R8 locked disable");
        fetch(at(8'h12, 21'h00_0004), "R8 region0 still live");

        // R9: re-enable refused.
        load(0, mk(1, 3, 8'h80, 11'h020, 0, 0), 0, "R9 reenable load");
        fetch(at(8'h12, 21'h00_0100), "R9 old contents kept");
        fetch(at(8'h80, 21'h00_0100), "R9 new contents absent");

        // R5: 128 MB entry.
        load(1, mk(1, 7, 8'hC0, 11'h7E0, 0, 0), 0, "R12 load region1");
        fetch(at(8'hED, 21'h1F_0F0F), "R5 128MB hit");
        fetch(at(8'h80, 21'h00_0001), "R4 128MB outside");

        // R7: overlap, lowest number wins; then disable and fall back.
        load(2, mk(1, 3, 8'hE8, 11'h010, 1, 1), 0, "R12 load region2");
        fetch(at(8'hEA, 21'h00_4444), "R7 region1 beats region2");
        load(1, mk(0, 7, 8'hC0, 11'h7E0, 0, 0), 0, "R9 disable region1");
        fetch(at(8'hEA, 21'h00_4444), "R7 region2 after disable");
        fetch(at(8'hF0, 21'h00_4444), "R4 8MB outside");

        // R10: size code 0 is inert.
        load(3, mk(1, 0, 8'h55, 11'h111, 1, 1), 0, "R10 load size0");
        fetch(at(8'h55, 21'h00_0000), "R10 size0 no hit");

        // Random phase: loads, lock toggles and biased fetches.
        for (int i = 0; i < 4000; i++) begin
            bit we = ($urandom % 6) == 0;
            bit cen = ($urandom % 4) == 0;
            int idx = int'($urandom % 4);
            logic [24:0] d = 25'($urandom);
            logic [31:0] a = $urandom;
            int pick = int'($urandom % 4);
            if ($urandom % 3 != 0)
                a[28:21] = 8'(m_base[pick]) ^ 8'($urandom % 4);
            if ($urandom % 5 == 0) d[0] = 1'b0;
            step(we, idx, d, cen, ($urandom % 8) != 0, a, "R7 random mix");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule